// File: doc/BRIEF.md
# Credit-Based Transmit Shaper Arbiter

This block chooses which of two frame queues may use a single transmit MAC port next: a high-priority audio/video (AV) queue that is rate-shaped, and a best-effort legacy queue. AV traffic of every stream class shares one shaper. A signed credit counter grows at a programmed idle slope for each byte time in which an AV frame is waiting. It shrinks at a programmed send slope for each AV byte that goes out. An AV frame can begin only when no frame is on the port and the credit is not negative. This holds AV traffic to its reserved share of the link, for example 75%, and leaves the rest of the link to legacy frames.

The credit is saturated at a programmed upper and lower bound. The usual bounds are the largest frame length multiplied by the idle slope and by the send slope. For example, a 2000-byte frame with an idle slope of 6144 gives an upper bound of 12288000. When the AV queue is empty, any positive credit is thrown away at once. A negative credit climbs back toward zero and stops at zero. Arbitration happens only between frames. A grant is held until the MAC reports the end of the frame.

Top module: `cbs_tx_arbiter`

## Requirements
- R1: During and directly after reset, `credit` reads 0 and both `grant_av` and `grant_lg` are low.
- R2: At most one grant is high at a time. A grant that is high stays unchanged until a cycle in which `frm_end` is high.
- R3: With no grant held, if `av_ready` is high and `credit` is zero or positive, `grant_av` rises on the next clock. The AV grant wins over a pending legacy frame. An AV grant is never issued while `credit` is negative.
- R4: With no grant held, `grant_lg` rises on the next clock if `lg_ready` is high and the AV queue cannot start, either because `av_ready` is low or because `credit` is negative.
- R5: While `grant_av` is high, each cycle with `byte_en` high lowers `credit` by `send_slope`. The result never goes below `lo_limit`.
- R6: While `grant_av` is low and `av_ready` is high, each cycle with `byte_en` high raises `credit` by `idle_slope`, up to at most `hi_limit`. This includes cycles in which a legacy frame holds the port.
- R7: While `grant_av` and `av_ready` are both low, a positive `credit` becomes 0 on the next clock, whatever the value of `byte_en`.
- R8: While `grant_av` and `av_ready` are both low, a negative `credit` rises by `idle_slope` on each cycle with `byte_en` high, and is capped at 0.
- R9: In any cycle not covered by R7, `credit` does not change when `byte_en` is low.
- R10: A `frm_end` pulse while a grant is held clears that grant on the next clock. The next grant can rise no earlier than the clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_en | input | 1 | One byte time elapses on the link in this cycle |
| av_ready | input | 1 | The AV queue holds at least one frame |
| lg_ready | input | 1 | The legacy queue holds at least one frame |
| frm_end | input | 1 | The frame now on the port finishes in this cycle |
| idle_slope | input | SW | Credit added per byte time while AV waits |
| send_slope | input | SW | Credit removed per AV byte sent |
| hi_limit | input | CW | Upper credit bound (signed, zero or positive) |
| lo_limit | input | CW | Lower credit bound (signed, zero or negative) |
| grant_av | output | 1 | The port is given to the AV queue |
| grant_lg | output | 1 | The port is given to the legacy queue |
| credit | output | CW | Current signed credit value |

## Verification
The assertions rely on three things about the inputs. `frm_end` pulses only while a grant is held. The limits satisfy `lo_limit <= 0 <= hi_limit`. The four configuration inputs change only while reset is held. The stimulus meets all three: it gates every random `frm_end` with the grant it expects to be active, and it loads each new configuration inside a reset pulse. Directed runs drive the credit all the way to both bounds and through the discard and recovery paths. Random runs use small limits so that saturation happens often.

// File: rtl/cbs_tx_arbiter.sv
module cbs_tx_arbiter #(
  parameter int CW = 32,
  parameter int SW = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 byte_en,
  input  logic                 av_ready,
  input  logic                 lg_ready,
  input  logic                 frm_end,
  input  logic [SW-1:0]        idle_slope,
  input  logic [SW-1:0]        send_slope,
  input  logic signed [CW-1:0] hi_limit,
  input  logic signed [CW-1:0] lo_limit,
  output logic                 grant_av,
  output logic                 grant_lg,
  output logic signed [CW-1:0] credit
);
  localparam int EW = CW + 1;

  logic busy, av_ok;
  logic signed [EW-1:0] up_sum, dn_sum, hi_x, lo_x;
  logic signed [CW-1:0] credit_nx;

  assign busy   = grant_av | grant_lg;
  assign av_ok  = av_ready & ~credit[CW-1];
  assign hi_x   = EW'(hi_limit);
  assign lo_x   = EW'(lo_limit);
  assign up_sum = EW'(credit) + $signed(EW'(idle_slope));
  assign dn_sum = EW'(credit) - $signed(EW'(send_slope));

  always_comb begin
    credit_nx = credit;
    if (grant_av) begin
      if (byte_en) credit_nx = (dn_sum < lo_x) ? lo_limit : dn_sum[CW-1:0];
    end else if (av_ready) begin
      if (byte_en) credit_nx = (up_sum > hi_x) ? hi_limit : up_sum[CW-1:0];
    end else if (credit > 0) begin
      credit_nx = '0;
    end else if (credit[CW-1] && byte_en) begin
      credit_nx = up_sum[CW] ? up_sum[CW-1:0] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      credit   <= '0;
      grant_av <= 1'b0;
      grant_lg <= 1'b0;
    end else begin
      credit <= credit_nx;
      if (busy) begin
        if (frm_end) begin
          grant_av <= 1'b0;
          grant_lg <= 1'b0;
        end
      end else if (av_ok) begin
        grant_av <= 1'b1;
      end else if (lg_ready) begin
        grant_lg <= 1'b1;
      end
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant_av, grant_lg})); // R2
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_av | grant_lg) && !frm_end |=> $stable({grant_av, grant_lg})); // R2
  AST_AV_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_av) |-> !$past(credit[CW-1])); // R3
  AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_av | grant_lg) && frm_end |=> !(grant_av | grant_lg)); // R10
  AST_DROP_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_av && !av_ready && (credit > 0) |=> credit == 0); // R7
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_en && !(!grant_av && !av_ready && (credit > 0)) |=> $stable(credit)); // R9
  AST_IN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (credit <= hi_limit) && (credit >= lo_limit)); // R5
endmodule

// File: tb/cbs_tx_arbiter_test.sv
module cbs_tx_arbiter_test;
  logic clk = 0, rst_n = 0;
  logic byte_en = 0, av_ready = 0, lg_ready = 0, frm_end = 0;
  logic [23:0] idle_slope, send_slope;
  logic signed [31:0] hi_limit, lo_limit;
  logic grant_av, grant_lg;
  logic signed [31:0] credit;

  int n_chk = 0, n_bad = 0;
  longint m_cred;
  bit m_gav, m_glg;
  string tag_c, tag_g;

  always #10 clk = ~clk;

  cbs_tx_arbiter uut (.clk(clk), .rst_n(rst_n), .byte_en(byte_en), .av_ready(av_ready),
    .lg_ready(lg_ready), .frm_end(frm_end), .idle_slope(idle_slope), .send_slope(send_slope),
    .hi_limit(hi_limit), .lo_limit(lo_limit), .grant_av(grant_av), .grant_lg(grant_lg),
    .credit(credit));

  task automatic compare();
    n_chk += 2;
    if (longint'(credit) != m_cred) begin
      n_bad++;
      $display("FAIL %s credit actual %0d expected %0d", tag_c, credit, m_cred);
    end
    if ({grant_av, grant_lg} != {m_gav, m_glg}) begin
      n_bad++;
      $display("FAIL %s grants actual %b%b expected %b%b", tag_g, grant_av, grant_lg, m_gav, m_glg);
    end
  endtask

  function automatic longint next_credit(bit a, bit b);
    longint c = m_cred;
    tag_c = "R9";
    if (m_gav) begin
      if (b) begin c = m_cred - send_slope; if (c < lo_limit) c = lo_limit; tag_c = "R5"; end
    end else if (a) begin
      if (b) begin c = m_cred + idle_slope; if (c > hi_limit) c = hi_limit; tag_c = "R6"; end
    end else if (m_cred > 0) begin
      c = 0; tag_c = "R7";
    end else if (m_cred < 0 && b) begin
      c = m_cred + idle_slope; if (c > 0) c = 0; tag_c = "R8";
    end
    return c;
  endfunction

  task automatic cyc(input bit a, input bit l, input bit b, input bit e);
    longint nc;
    e = e & (m_gav | m_glg);
    av_ready = a; lg_ready = l; byte_en = b; frm_end = e;
    nc = next_credit(a, b);
    if (m_gav | m_glg) begin
      if (e) begin m_gav = 0; m_glg = 0; tag_g = "R10"; end
      else tag_g = "R2";
    end else if (a && m_cred >= 0) begin m_gav = 1; tag_g = "R3"; end
    else if (l) begin m_glg = 1; tag_g = "R4"; end
    else tag_g = "R3";
    m_cred = nc;
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset(input int is, input int ss, input int hi, input int lo);
    @(negedge clk);
    rst_n = 0; av_ready = 0; lg_ready = 0; byte_en = 0; frm_end = 0;
    idle_slope = 24'(is); send_slope = 24'(ss); hi_limit = hi; lo_limit = lo;
    repeat (2) @(negedge clk);
    m_cred = 0; m_gav = 0; m_glg = 0; tag_c = "R1"; tag_g = "R1";
    compare();
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset(6144, 2048, 12288000, -4096000);               // R1
    cyc(0, 1, 1, 0);                                        // R4 legacy takes idle port
    for (int i = 0; i < 2100; i++) cyc(1, 0, 1, 0);         // R6 blocked AV accrues, caps at hi
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0);            // R9 no byte time
    cyc(1, 1, 1, 1);                                        // R10 legacy ends
    cyc(1, 1, 1, 0);                                        // R3 AV wins
    for (int i = 0; i < 8100; i++) cyc(0, 1, 1, 0);         // R5 send, floors at lo
    cyc(0, 1, 1, 1);                                        // R10
    cyc(0, 0, 1, 0);
    for (int i = 0; i < 700; i++) cyc(0, 0, 1, 0);          // R8 recovers, stops at 0
    cyc(0, 1, 1, 0);                                        // R4
    for (int i = 0; i < 4; i++) cyc(1, 0, 1, 0);            // R6
    cyc(0, 0, 0, 0);                                        // R7 positive dropped
    cyc(0, 0, 1, 1);

    do_reset(5000, 7000, 30000, -20000);                    // R1
    for (int i = 0; i < 20000; i++) begin
      bit a = ($urandom_range(0, 3) != 0);
      bit l = ($urandom_range(0, 1) != 0);
      bit b = ($urandom_range(0, 9) < 7);
      bit e = ($urandom_range(0, 5) == 0);
      cyc(a, l, b, e);
    end
    do_reset(300, 900, 4000, -2700);                        // R1
    for (int i = 0; i < 5000; i++)
      cyc($urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0,
          $urandom_range(0, 1) != 0, $urandom_range(0, 3) == 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule